// File: doc/BRIEF.md
# VLAN Membership and Tagging Table

This block classifies each frame of a seven-port switch into a VLAN and says where the frame may go. A lookup presents the ingress port, a flag saying whether the frame carried a tag, and the VID from that tag. The block then chooses the classification VID:

- An untagged frame takes the default VID of its ingress port.
- A tagged frame keeps its own VID.
- A port with VLAN handling switched off puts every frame into VID 0.
- A port in double-tag mode ignores the frame's tag and uses its default VID.

The chosen VID is searched for in a sixteen-entry membership table. One clock later the block returns:

- the member port set of the matching entry;
- the ports on which the frame must leave without a tag.

Port 6 is the CPU port. The table, the default VIDs and the per-port control bits are written and read through a word-addressed register port. Several values share one word: two VIDs per word, four member masks per word, and two default VIDs per word. The packing is fixed because software computes word and shift from the entry or port index.

Top module: `vlan_tag_table`

## Requirements
- R1: After a synchronous reset, every entry VID reads 0xFFF and every member mask reads 0. Every port default VID and all three control masks read 0. `res_valid` is 0.
- R2: Word addresses 0 to 7 hold the VIDs. Word n keeps entry 2n in bits 11:0 and entry 2n+1 in bits 23:12. Bits 31:24 read as 0, and writing them has no effect.
- R3: Word addresses 8 to 11 hold the member masks. Word 8+n keeps entries 4n to 4n+3, one byte each, with entry 4n in bits 7:0. All eight bits of each byte read back as written.
- R4: Word addresses 12 to 15 hold the port default VIDs. Word 12+n keeps port 2n in bits 11:0 and port 2n+1 in bits 23:12. The slot for the nonexistent port 7 (word 15, bits 23:12) reads 0 and ignores writes.
- R5: Word address 16 is the control word. Bits 6:0 are the per-port untag mask, bits 14:8 the per-port VLAN-enable mask and bits 22:16 the per-port double-tag mask, with bit k belonging to port k.
- R6: The classification VID is chosen as follows, in order of precedence:
  - 0 when VLAN handling is off for the ingress port;
  - the port's default VID when the frame is untagged or the port is in double-tag mode;
  - otherwise the frame's own VID.
- R7: An entry matches when its VID equals the classification VID, at least one of its bits 6:0 is set, and its VID is not 0xFFF. When several entries match, the lowest-numbered one is used.
- R8: A lookup with no matching entry returns `res_hit`=0, an all-zero port mask and an all-zero untag mask. A lookup from port 7 returns the same, with `res_vid`=0xFFF.
- R9: On a hit, the untag mask equals the member mask ANDed with the per-port untag mask. When the classification VID is 0, the untag mask equals the member mask, so no tag is ever added.
- R10: The result of a lookup appears on the outputs on the clock edge after `lk_valid` is sampled high, with `res_valid`=1 and `res_vid` showing the classification VID. In a cycle that follows no lookup, all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_port | input | 3 | Ingress port of the frame |
| lk_tagged | input | 1 | Frame arrived with a VLAN tag |
| lk_vid | input | 12 | VID from the frame's tag |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | A table entry matched |
| res_vid | output | 12 | Classification VID |
| res_ports | output | 7 | Member port set of the matching entry |
| res_untag | output | 7 | Ports on which the frame leaves untagged |

## Verification
The hardest case to reach from the ports is the interplay of entry priority and entry validity. The same VID has to sit in two slots at once. The lower slot must then become invalid only because its member byte was cleared, while its VID field stays untouched. The stimulus programs VID 0x045 into entries 2 and 5 and checks that entry 2 wins. It then rewrites the member word so that entry 2's byte is zero and checks that the result moves to entry 5. Related cases follow the same pattern: an entry whose VID is 0xFFF, and an entry whose only member bit is the unused bit 7, are each given a nonzero mask and shown never to match.

// File: rtl/vtt_pkg.sv
package vtt_pkg;

    localparam int VTT_ENTRIES   = 16;
    localparam int VTT_PORTS     = 7;
    localparam int VTT_VID_W     = 12;
    localparam int VTT_MASK_W    = 8;
    localparam int VTT_DATA_W    = 32;
    localparam int VTT_ADDR_W    = 5;

    localparam int VTT_VID_PER_WORD  = 2;
    localparam int VTT_MASK_PER_WORD = 4;
    localparam int VTT_PVID_SLOTS    = ((VTT_PORTS + 1) / 2) * 2;

    localparam int VTT_VID_WORDS  = VTT_ENTRIES / VTT_VID_PER_WORD;
    localparam int VTT_MASK_WORDS = VTT_ENTRIES / VTT_MASK_PER_WORD;
    localparam int VTT_PVID_WORDS = VTT_PVID_SLOTS / VTT_VID_PER_WORD;

    localparam int VTT_VID_BASE  = 0;
    localparam int VTT_MASK_BASE = VTT_VID_BASE + VTT_VID_WORDS;
    localparam int VTT_PVID_BASE = VTT_MASK_BASE + VTT_MASK_WORDS;
    localparam int VTT_CTRL_ADDR = VTT_PVID_BASE + VTT_PVID_WORDS;

    localparam int VTT_CTRL_UNTAG_LSB = 0;
    localparam int VTT_CTRL_VEN_LSB   = 8;
    localparam int VTT_CTRL_DTAG_LSB  = 16;

    localparam int VTT_PORT_W = $clog2(VTT_PORTS + 1);

    typedef logic [VTT_VID_W-1:0] vid_t;
    typedef logic [VTT_PORTS-1:0] pmask_t;

    localparam vid_t VID_UNUSED = '1;
    localparam vid_t VID_NOTAG  = '0;

    typedef enum logic [2:0] {
        RGN_VID,
        RGN_MEMBER,
        RGN_PVID,
        RGN_CTRL,
        RGN_NONE
    } vtt_region_e;

    typedef struct packed {
        logic   valid;
        logic   hit;
        vid_t   vid;
        pmask_t ports;
        pmask_t untag;
    } vtt_result_t;

    function automatic vtt_region_e vtt_region(input logic [VTT_ADDR_W-1:0] a);
        int ai;
        ai = int'(a);
        if (ai < VTT_MASK_BASE)       return RGN_VID;
        else if (ai < VTT_PVID_BASE)  return RGN_MEMBER;
        else if (ai < VTT_CTRL_ADDR)  return RGN_PVID;
        else if (ai == VTT_CTRL_ADDR) return RGN_CTRL;
        else                          return RGN_NONE;
    endfunction

    function automatic int vtt_offset(input logic [VTT_ADDR_W-1:0] a);
        int ai;
        ai = int'(a);
        if (ai < VTT_MASK_BASE)      return ai - VTT_VID_BASE;
        else if (ai < VTT_PVID_BASE) return ai - VTT_MASK_BASE;
        else if (ai < VTT_CTRL_ADDR) return ai - VTT_PVID_BASE;
        else                         return 0;
    endfunction

endpackage

// File: rtl/vtt_regfile.sv
module vtt_regfile
    import vtt_pkg::*;
#(
    parameter int NUM_ENTRIES = VTT_ENTRIES,
    parameter int NUM_PORTS   = VTT_PORTS,
    parameter int VID_W       = VTT_VID_W,
    parameter int MASK_W      = VTT_MASK_W,
    parameter int DATA_W      = VTT_DATA_W,
    parameter int ADDR_W      = VTT_ADDR_W
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  cfg_we,
    input  logic [ADDR_W-1:0]                     cfg_addr,
    input  logic [DATA_W-1:0]                     cfg_wdata,
    output logic [DATA_W-1:0]                     cfg_rdata,
    output logic [NUM_ENTRIES-1:0][VID_W-1:0]     ent_vid,
    output logic [NUM_ENTRIES-1:0][NUM_PORTS-1:0] ent_ports,
    output logic [NUM_PORTS-1:0][VID_W-1:0]       port_pvid,
    output logic [NUM_PORTS-1:0]                  untag_mask,
    output logic [NUM_PORTS-1:0]                  ven_mask,
    output logic [NUM_PORTS-1:0]                  dtag_mask
);

    localparam int VPW = VTT_VID_PER_WORD;
    localparam int MPW = VTT_MASK_PER_WORD;

    logic [NUM_ENTRIES-1:0][VID_W-1:0]  vid_q;
    logic [NUM_ENTRIES-1:0][MASK_W-1:0] mem_q;
    logic [NUM_PORTS-1:0][VID_W-1:0]    pvid_q;
    logic [NUM_PORTS-1:0]               untag_q, ven_q, dtag_q;

    vtt_region_e rgn;
    int          off;

    always_comb begin
        rgn = vtt_region(cfg_addr);
        off = vtt_offset(cfg_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vid_q   <= '1;
            mem_q   <= '0;
            pvid_q  <= '0;
            untag_q <= '0;
            ven_q   <= '0;
            dtag_q  <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (rgn == RGN_VID && off == i / VPW)
                    vid_q[i] <= cfg_wdata[(i % VPW) * VID_W +: VID_W];
                if (rgn == RGN_MEMBER && off == i / MPW)
                    mem_q[i] <= cfg_wdata[(i % MPW) * MASK_W +: MASK_W];
            end
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (rgn == RGN_PVID && off == p / VPW)
                    pvid_q[p] <= cfg_wdata[(p % VPW) * VID_W +: VID_W];
            end
            if (rgn == RGN_CTRL) begin
                untag_q <= cfg_wdata[VTT_CTRL_UNTAG_LSB +: NUM_PORTS];
                ven_q   <= cfg_wdata[VTT_CTRL_VEN_LSB   +: NUM_PORTS];
                dtag_q  <= cfg_wdata[VTT_CTRL_DTAG_LSB  +: NUM_PORTS];
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (rgn)
            RGN_VID: begin
                for (int i = 0; i < NUM_ENTRIES; i++)
                    if (off == i / VPW)
                        cfg_rdata[(i % VPW) * VID_W +: VID_W] = vid_q[i];
            end
            RGN_MEMBER: begin
                for (int i = 0; i < NUM_ENTRIES; i++)
                    if (off == i / MPW)
                        cfg_rdata[(i % MPW) * MASK_W +: MASK_W] = mem_q[i];
            end
            RGN_PVID: begin
                for (int p = 0; p < NUM_PORTS; p++)
                    if (off == p / VPW)
                        cfg_rdata[(p % VPW) * VID_W +: VID_W] = pvid_q[p];
            end
            RGN_CTRL: begin
                cfg_rdata[VTT_CTRL_UNTAG_LSB +: NUM_PORTS] = untag_q;
                cfg_rdata[VTT_CTRL_VEN_LSB   +: NUM_PORTS] = ven_q;
                cfg_rdata[VTT_CTRL_DTAG_LSB  +: NUM_PORTS] = dtag_q;
            end
            default: cfg_rdata = '0;
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < NUM_ENTRIES; g++) begin : g_ent
            assign ent_vid[g]   = vid_q[g];
            assign ent_ports[g] = mem_q[g][NUM_PORTS-1:0];
        end
    endgenerate

    assign port_pvid  = pvid_q;
    assign untag_mask = untag_q;
    assign ven_mask   = ven_q;
    assign dtag_mask  = dtag_q;

endmodule

// File: rtl/vtt_classify.sv
module vtt_classify
    import vtt_pkg::*;
#(
    parameter int NUM_PORTS = VTT_PORTS,
    parameter int VID_W     = VTT_VID_W,
    parameter int PORT_W    = VTT_PORT_W
) (
    input  logic [PORT_W-1:0]             lk_port,
    input  logic                          lk_tagged,
    input  logic [VID_W-1:0]              lk_vid,
    input  logic [NUM_PORTS-1:0][VID_W-1:0] port_pvid,
    input  logic [NUM_PORTS-1:0]          ven_mask,
    input  logic [NUM_PORTS-1:0]          dtag_mask,
    output logic                          port_ok,
    output logic [VID_W-1:0]              cls_vid
);

    logic [VID_W-1:0] sel_pvid;
    logic             sel_ven, sel_dtag;

    always_comb begin
        port_ok  = 1'b0;
        sel_pvid = '0;
        sel_ven  = 1'b0;
        sel_dtag = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (int'(lk_port) == p) begin
                port_ok  = 1'b1;
                sel_pvid = port_pvid[p];
                sel_ven  = ven_mask[p];
                sel_dtag = dtag_mask[p];
            end
        end
    end

    always_comb begin
        if (!port_ok)                   cls_vid = '1;
        else if (!sel_ven)              cls_vid = '0;
        else if (!lk_tagged || sel_dtag) cls_vid = sel_pvid;
        else                            cls_vid = lk_vid;
    end

endmodule

// File: rtl/vtt_match.sv
module vtt_match
    import vtt_pkg::*;
#(
    parameter int NUM_ENTRIES = VTT_ENTRIES,
    parameter int NUM_PORTS   = VTT_PORTS,
    parameter int VID_W       = VTT_VID_W
) (
    input  logic [VID_W-1:0]                      key_vid,
    input  logic [NUM_ENTRIES-1:0][VID_W-1:0]     ent_vid,
    input  logic [NUM_ENTRIES-1:0][NUM_PORTS-1:0] ent_ports,
    output logic                                  hit,
    output logic [NUM_PORTS-1:0]                  hit_ports
);

    logic [NUM_ENTRIES-1:0] hv;

    genvar g;
    generate
        for (g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
            assign hv[g] = (ent_vid[g] == key_vid) &&
                           (|ent_ports[g]) &&
                           (ent_vid[g] != {VID_W{1'b1}});
        end
    endgenerate

    always_comb begin
        hit       = 1'b0;
        hit_ports = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hv[i]) begin
                hit       = 1'b1;
                hit_ports = ent_ports[i];
            end
        end
    end

endmodule

// File: rtl/vlan_tag_table.sv
module vlan_tag_table
    import vtt_pkg::*;
#(
    parameter int NUM_ENTRIES = VTT_ENTRIES,
    parameter int NUM_PORTS   = VTT_PORTS,
    parameter int VID_W       = VTT_VID_W,
    parameter int MASK_W      = VTT_MASK_W,
    parameter int DATA_W      = VTT_DATA_W,
    parameter int ADDR_W      = VTT_ADDR_W,
    parameter int PORT_W      = VTT_PORT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic                 lk_valid,
    input  logic [PORT_W-1:0]    lk_port,
    input  logic                 lk_tagged,
    input  logic [VID_W-1:0]     lk_vid,
    output logic                 res_valid,
    output logic                 res_hit,
    output logic [VID_W-1:0]     res_vid,
    output logic [NUM_PORTS-1:0] res_ports,
    output logic [NUM_PORTS-1:0] res_untag
);

    logic [NUM_ENTRIES-1:0][VID_W-1:0]     ent_vid;
    logic [NUM_ENTRIES-1:0][NUM_PORTS-1:0] ent_ports;
    logic [NUM_PORTS-1:0][VID_W-1:0]       port_pvid;
    logic [NUM_PORTS-1:0]                  untag_mask, ven_mask, dtag_mask;

    logic                 port_ok;
    logic [VID_W-1:0]     cls_vid;
    logic                 m_hit;
    logic [NUM_PORTS-1:0] m_ports;

    vtt_result_t res_d, res_q;

    vtt_regfile #(
        .NUM_ENTRIES(NUM_ENTRIES), .NUM_PORTS(NUM_PORTS), .VID_W(VID_W),
        .MASK_W(MASK_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .ent_vid    (ent_vid),
        .ent_ports  (ent_ports),
        .port_pvid  (port_pvid),
        .untag_mask (untag_mask),
        .ven_mask   (ven_mask),
        .dtag_mask  (dtag_mask)
    );

    vtt_classify #(
        .NUM_PORTS(NUM_PORTS), .VID_W(VID_W), .PORT_W(PORT_W)
    ) u_cls (
        .lk_port   (lk_port),
        .lk_tagged (lk_tagged),
        .lk_vid    (lk_vid),
        .port_pvid (port_pvid),
        .ven_mask  (ven_mask),
        .dtag_mask (dtag_mask),
        .port_ok   (port_ok),
        .cls_vid   (cls_vid)
    );

    vtt_match #(
        .NUM_ENTRIES(NUM_ENTRIES), .NUM_PORTS(NUM_PORTS), .VID_W(VID_W)
    ) u_match (
        .key_vid   (cls_vid),
        .ent_vid   (ent_vid),
        .ent_ports (ent_ports),
        .hit       (m_hit),
        .hit_ports (m_ports)
    );

    always_comb begin
        res_d = '0;
        if (lk_valid) begin
            res_d.valid = 1'b1;
            res_d.vid   = cls_vid;
            if (port_ok && m_hit) begin
                res_d.hit   = 1'b1;
                res_d.ports = m_ports;
                res_d.untag = (cls_vid == VID_NOTAG) ? m_ports : (m_ports & untag_mask);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign res_hit   = res_q.hit;
    assign res_vid   = res_q.vid;
    assign res_ports = res_q.ports;
    assign res_untag = res_q.untag;

endmodule

// File: rtl/vtt_checker.sv
module vtt_checker #(
    parameter int NUM_PORTS = 7,
    parameter int VID_W     = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 lk_valid,
    input logic                 res_valid,
    input logic                 res_hit,
    input logic [VID_W-1:0]     res_vid,
    input logic [NUM_PORTS-1:0] res_ports,
    input logic [NUM_PORTS-1:0] res_untag
);

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);  // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!res_valid && !res_hit && res_ports == '0 && res_untag == '0));  // R10

    AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_ports == '0 && res_untag == '0));  // R8

    AST_HIT_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> (res_ports != '0 && res_vid != {VID_W{1'b1}}));  // R7

    AST_UNTAG_SUBSET: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((res_untag & ~res_ports) == '0));  // R9

    AST_VID0_NOTAG: assert property (@(posedge clk) disable iff (rst)
        (res_hit && res_vid == '0) |-> (res_untag == res_ports));  // R9

endmodule

bind vlan_tag_table vtt_checker #(.NUM_PORTS(NUM_PORTS), .VID_W(VID_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_vid   (res_vid),
    .res_ports (res_ports),
    .res_untag (res_untag)
);

// File: tb/vlan_tag_table_tb_top.sv
`timescale 1ns/1ps
module vlan_tag_table_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lk_valid = 1'b0;
    logic [2:0]  lk_port = '0;
    logic        lk_tagged = 1'b0;
    logic [11:0] lk_vid = '0;
    logic        res_valid, res_hit;
    logic [11:0] res_vid;
    logic [6:0]  res_ports, res_untag;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    vlan_tag_table dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
        .lk_port(lk_port), .lk_tagged(lk_tagged), .lk_vid(lk_vid),
        .res_valid(res_valid), .res_hit(res_hit), .res_vid(res_vid),
        .res_ports(res_ports), .res_untag(res_untag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic look(input string req, input logic [2:0] p, input logic tg,
                        input logic [11:0] v, input logic e_hit, input logic [11:0] e_vid,
                        input logic [6:0] e_ports, input logic [6:0] e_untag);
        @(negedge clk);
        lk_valid = 1'b1; lk_port = p; lk_tagged = tg; lk_vid = v;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({req, " R10 valid"}, res_valid, 1);
        chk({req, " hit"}, res_hit, e_hit);
        chk({req, " vid"}, res_vid, e_vid);
        chk({req, " ports"}, res_ports, e_ports);
        chk({req, " untag"}, res_untag, e_untag);
    endtask

    task automatic t_reset();
        chk("R1 res_valid", res_valid, 0);
        rd_chk("R1 vid word", 5'd0, 32'h00FF_FFFF);
        rd_chk("R1 member word", 5'd8, 32'h0);
        rd_chk("R1 pvid word", 5'd12, 32'h0);
        rd_chk("R1 ctrl word", 5'd16, 32'h0);
        look("R8 reset miss", 3'd1, 1'b1, 12'h045, 1'b0, 12'h000, 7'h00, 7'h00);
    endtask

    task automatic t_packing();
        wr(5'd1, 32'hAB12_3045);
        rd_chk("R2 vid pair", 5'd1, 32'h0012_3045);
        wr(5'd8, 32'h410F_0000);
        rd_chk("R3 member bytes", 5'd8, 32'h410F_0000);
        wr(5'd13, 32'h0012_3123);
        rd_chk("R4 pvid pair", 5'd13, 32'h0012_3123);
        wr(5'd15, 32'h00FF_FABC);
        rd_chk("R4 port7 slot", 5'd15, 32'h0000_0ABC);
        wr(5'd16, 32'h0004_7E01);
        rd_chk("R5 ctrl fields", 5'd16, 32'h0004_7E01);
    endtask

    task automatic t_classify();
        look("R6 tagged own vid", 3'd1, 1'b1, 12'h045, 1'b1, 12'h045, 7'h0F, 7'h01);
        look("R6 untagged pvid", 3'd3, 1'b0, 12'h045, 1'b1, 12'h123, 7'h41, 7'h01);
        look("R6 double-tag pvid", 3'd2, 1'b1, 12'h045, 1'b1, 12'h123, 7'h41, 7'h01);
    endtask

    task automatic t_vid0();
        wr(5'd0, 32'h00FF_F000);
        look("R8 vid0 empty miss", 3'd0, 1'b1, 12'h045, 1'b0, 12'h000, 7'h00, 7'h00);
        wr(5'd8, 32'h410F_007F);
        look("R9 vid0 notag", 3'd0, 1'b1, 12'h045, 1'b1, 12'h000, 7'h7F, 7'h7F);
    endtask

    task automatic t_priority();
        wr(5'd2, 32'h0004_5FFF);
        wr(5'd9, 32'h0000_3000);
        look("R7 lowest wins", 3'd1, 1'b1, 12'h045, 1'b1, 12'h045, 7'h0F, 7'h01);
        wr(5'd8, 32'h4100_007F);
        look("R7 empty skipped", 3'd1, 1'b1, 12'h045, 1'b1, 12'h045, 7'h30, 7'h00);
    endtask

    task automatic t_invalid_entries();
        wr(5'd9, 32'h0000_3001);
        look("R7 fff never matches", 3'd1, 1'b1, 12'hFFF, 1'b0, 12'hFFF, 7'h00, 7'h00);
        wr(5'd3, 32'h00FF_F200);
        wr(5'd9, 32'h0080_3001);
        rd_chk("R3 bit7 kept", 5'd9, 32'h0080_3001);
        look("R7 bit7 only empty", 3'd1, 1'b1, 12'h200, 1'b0, 12'h200, 7'h00, 7'h00);
        look("R8 table miss", 3'd1, 1'b1, 12'h777, 1'b0, 12'h777, 7'h00, 7'h00);
    endtask

    task automatic t_badport_idle();
        look("R8 port7", 3'd7, 1'b1, 12'h045, 1'b0, 12'hFFF, 7'h00, 7'h00);
        @(negedge clk);
        chk("R10 idle valid", res_valid, 0);
        chk("R10 idle ports", res_ports, 0);
        chk("R10 idle vid", res_vid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_packing();
        t_classify();
        t_vid0();
        t_priority();
        t_invalid_entries();
        t_badport_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule